// File: doc/BRIEF.md
# Reaction Time Meter

This block measures how quickly a person responds to a visual prompt. The sequence starts with a reset, which puts the block at rest with the displayed result at zero. The person then presses and releases a push button. After the release, the block waits for a pulse from an external delay generator. When that pulse arrives, a prompt LED lights and a decimal millisecond count begins. The person presses the button again as fast as possible. That press stops the count and holds the result on the display until the next reset.

The count is kept as a chain of BCD digits. Each digit runs from 0 to 9 and carries into the next higher digit, so the display path can turn each nibble into a glyph with no conversion. The count advances once on each cycle where the `tick` enable is high. `tick` is the 1 ms time base, so the count is the elapsed time in milliseconds.

The button is raw. It passes through a two-flop synchronizer, and the block detects presses and releases as single-cycle edges. A press made before the LED lights is a false start and is ignored. If the person never responds, the count stops at all nines, an overflow flag rises and the result freezes.

The controller is a Moore machine: every output is decoded from the current state alone.

Top module: `rxn_meter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to rest. After reset, every digit reads 0 and `led`, `running`, `done` and `overflow` are all low.
- R2: At rest, `wait_done` has no effect. This holds both before the button is pressed and while the first press is still held.
- R3: The first `wait_done` pulse after the button has been pressed and released lights `led` and raises `running`. Both outputs are high in the cycle after the clock edge that sampled the pulse, and the digits read 0 at that point.
- R4: While `running` is high, the count rises by exactly one on each clock edge where `tick` is high. It holds its value on every edge where `tick` is low.
- R5: A new button press while running stops the count. `done` goes high, `led` and `running` go low, and the digits stay frozen. Later ticks, presses and `wait_done` pulses leave everything unchanged until reset.
- R6: A press, or a press and release, made after arming but before `wait_done` arrives is ignored. The block keeps waiting, and the next `wait_done` pulse starts timing normally.
- R7: `digits` holds DIGITS BCD nibbles, with digit 0 (least significant) in bits [3:0]. Every nibble stays within 0 to 9. A digit rolls from 9 to 0 and carries into the next higher digit, so 10 ticks read 0x010 and 100 ticks read 0x100.
- R8: A tick that arrives while every digit reads 9 does not wrap the count. On that tick the count stays at all nines, `overflow` and `done` rise, `running` and `led` fall, and the result freezes as in R5.
- R9: Only a rising edge of the synchronized button stops the count. A button held down continuously from the waiting phase into timing does not stop the count.
- R10: The count is zero whenever the block is at rest, armed or waiting. A run started after a reset therefore always begins from zero, even when the previous result was nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle enable at the 1 ms rate |
| btn | input | 1 | Raw start/stop push button, high when pressed |
| wait_done | input | 1 | Pulse from the delay generator |
| led | output | 1 | Prompt LED, lit while timing |
| running | output | 1 | High while the count is advancing |
| done | output | 1 | Result frozen |
| overflow | output | 1 | Count saturated at all nines |
| digits | output | 4*DIGITS | BCD result, digit 0 in bits [3:0] |

## Verification
The bench builds the block with DIGITS set to 3, so saturation is reached after 999 ticks rather than 9999. This keeps the all-nines stop, the overflow flag and the carries out of both lower digits within a short run. The bench drives `tick` itself and leaves idle cycles between ticks. This shows that the count advances only on enabled cycles and does not simply follow the clock.

// File: rtl/rxn_meter.sv
module rxn_meter #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                btn,
  input  logic                wait_done,
  output logic                led,
  output logic                running,
  output logic                done,
  output logic                overflow,
  output logic [4*DIGITS-1:0] digits
);
  localparam int W = 4 * DIGITS;

  typedef enum logic [2:0] {S_REST, S_ARMED, S_DELAY, S_RUN, S_HOLD, S_OVF} state_t;
  state_t state, state_nx;

  logic btn_m, btn_s, btn_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      btn_m <= 1'b0;
      btn_s <= 1'b0;
      btn_q <= 1'b0;
    end else begin
      btn_m <= btn;
      btn_s <= btn_m;
      btn_q <= btn_s;
    end
  end

  wire press   = btn_s & ~btn_q;
  wire release_e = ~btn_s & btn_q;

  logic [DIGITS-1:0] is_nine;
  logic [DIGITS:0]   carry;
  wire all_nines = &is_nine;
  wire clr       = (state == S_REST) || (state == S_ARMED) || (state == S_DELAY);
  wire step      = (state == S_RUN) && tick && !press && !all_nines;

  assign carry[0] = step;

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_dig
      logic [3:0] d;
      assign is_nine[g]    = (d == 4'd9);
      assign carry[g+1]    = carry[g] & is_nine[g];
      assign digits[4*g +: 4] = d;
      always_ff @(posedge clk) begin
        if (rst || clr)    d <= 4'd0;
        else if (carry[g]) d <= is_nine[g] ? 4'd0 : d + 4'd1;
      end
      AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst) d <= 4'd9); // R7
    end
  endgenerate

  always_comb begin
    state_nx = state;
    unique case (state)
      S_REST:  if (press)     state_nx = S_ARMED;
      S_ARMED: if (release_e) state_nx = S_DELAY;
      S_DELAY: if (wait_done) state_nx = S_RUN;
      S_RUN: begin
        if (press)                 state_nx = S_HOLD;
        else if (tick && all_nines) state_nx = S_OVF;
      end
      S_HOLD:  state_nx = S_HOLD;
      S_OVF:   state_nx = S_OVF;
      default: state_nx = S_REST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_REST;
    else     state <= state_nx;
  end

  assign led      = (state == S_RUN);
  assign running  = (state == S_RUN);
  assign done     = (state == S_HOLD) || (state == S_OVF);
  assign overflow = (state == S_OVF);

  AST_RESET_REST: assert property (@(posedge clk) rst |=> (digits == '0 && !led && !done && !overflow)); // R1
  AST_LED_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst) $rose(led) |-> $past(wait_done)); // R3
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (rst) (running && !tick) |=> $stable(digits)); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst) (done && $past(done)) |-> $stable(digits)); // R5
  AST_SATURATED: assert property (@(posedge clk) disable iff (rst) overflow |-> (digits == {DIGITS{4'd9}})); // R8
  AST_ZERO_BEFORE_RUN: assert property (@(posedge clk) disable iff (rst) (!running && !done) |-> (digits == {W{1'b0}})); // R10
endmodule

// File: tb/rxn_meter_test.sv
module rxn_meter_test;
  localparam int DIGITS = 3;
  localparam int W = 4 * DIGITS;

  logic clk = 0, rst = 1, tick = 0, btn = 0, wait_done = 0;
  logic led, running, done, overflow;
  logic [W-1:0] digits;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rxn_meter #(.DIGITS(DIGITS)) uut (
    .clk(clk), .rst(rst), .tick(tick), .btn(btn), .wait_done(wait_done),
    .led(led), .running(running), .done(done), .overflow(overflow), .digits(digits)
  );

  function automatic logic [W-1:0] bcd(input int n);
    logic [W-1:0] r = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic flags(input string req, input bit l, input bit r, input bit d, input bit o);
    chk({led, running, done, overflow} == {l, r, d, o}, req, "led/run/done/ovf",
        {led, running, done, overflow}, {l, r, d, o});
  endtask

  task automatic cnt(input string req, input int n);
    chk(digits == bcd(n), req, "digits", digits, bcd(n));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1; btn = 0; tick = 0; wait_done = 0;
    idle(2); rst = 0; idle(1);
  endtask

  task automatic set_btn(input bit v);
    @(negedge clk); btn = v; idle(4);
  endtask

  task automatic pulse_wd;
    @(negedge clk); wait_done = 1; @(negedge clk); wait_done = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic start_run;
    set_btn(1); set_btn(0); pulse_wd;
  endtask

  task automatic t_reset;
    do_reset;
    flags("R1", 0, 0, 0, 0); cnt("R1", 0);
  endtask

  task automatic t_arm_and_measure;
    do_reset;
    pulse_wd; idle(3); flags("R2", 0, 0, 0, 0);
    set_btn(1); pulse_wd; idle(3); flags("R2", 0, 0, 0, 0);
    set_btn(0); idle(3); flags("R2", 0, 0, 0, 0);
    pulse_wd; flags("R3", 1, 1, 0, 0); cnt("R3", 0);
    ticks(37); idle(3); cnt("R4", 37);
    set_btn(1); flags("R5", 0, 0, 1, 0); cnt("R5", 37);
    set_btn(0); ticks(5); set_btn(1); pulse_wd; ticks(3); set_btn(0);
    flags("R5", 0, 0, 1, 0); cnt("R5", 37);
    do_reset; cnt("R10", 0); start_run; cnt("R10", 0); flags("R10", 1, 1, 0, 0);
  endtask

  task automatic t_carry;
    do_reset; start_run;
    ticks(9); cnt("R7", 9);
    ticks(1); cnt("R7", 10);
    ticks(90); cnt("R7", 100);
  endtask

  task automatic t_false_start;
    do_reset; set_btn(1); set_btn(0);
    set_btn(1); set_btn(0); idle(3); flags("R6", 0, 0, 0, 0);
    pulse_wd; flags("R6", 1, 1, 0, 0);
    ticks(4); cnt("R6", 4);
  endtask

  task automatic t_held;
    do_reset; set_btn(1); set_btn(0); set_btn(1);
    pulse_wd; flags("R9", 1, 1, 0, 0);
    ticks(5); flags("R9", 1, 1, 0, 0); cnt("R9", 5);
    set_btn(0); set_btn(1); flags("R9", 0, 0, 1, 0); cnt("R9", 5);
  endtask

  task automatic t_saturate;
    do_reset; start_run;
    ticks(999); cnt("R8", 999); flags("R8", 1, 1, 0, 0);
    ticks(1); cnt("R8", 999); flags("R8", 0, 0, 1, 1);
    ticks(4); cnt("R8", 999);
    do_reset; cnt("R1", 0); flags("R1", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset;
    t_arm_and_measure;
    t_carry;
    t_false_start;
    t_held;
    t_saturate;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule